// File: doc/BRIEF.md
# Hart privilege state and data-access privilege unit

This block keeps the privilege state of one hart: the nominal privilege level, the virtualization flag, and the machine status fields that save and restore that state across traps and returns. Those fields are the previous privilege, the previous virtualization, the modify-privilege flag, the interrupt enable and its saved copy, and the supervisor previous privilege. It reacts to a trap strobe, to machine-return and supervisor-return strobes, and to a field-level status write port.

It produces two views of privilege. The nominal view drives instruction fetch and implicit accesses. The effective view drives explicit loads and stores. While the modify-privilege flag is set, the effective view takes the saved previous privilege and previous virtualization. The nominal level is never changed by that flag.

Privilege is encoded as 0 for user, 1 for supervisor and 3 for machine. The block keeps one invariant: whenever a machine-level trap handler is entered, a set modify-privilege flag is always paired with a saved previous privilege of machine level.

Top module: `priv_state_unit`

## Requirements
- R1: After reset the nominal privilege is 3, virtualization is 0, and the modify-privilege flag, the previous privilege, the previous virtualization, the interrupt enable, the saved enable and the supervisor previous privilege are all 0.
- R2: A trap has several effects in the next cycle. The previous privilege takes the nominal privilege and the previous virtualization takes the virtualization flag, both as they were before the trap. The saved enable takes the interrupt enable, and the interrupt enable clears. The nominal privilege becomes 3 and virtualization becomes 0. The modify-privilege flag is unchanged.
- R3: When the modify-privilege flag is 1, the effective privilege and virtualization equal the previous privilege and previous virtualization. When the flag is 0, they equal the nominal values. The nominal outputs never depend on the flag.
- R4: A machine return has several effects. The nominal privilege takes the previous privilege. Virtualization takes the previous virtualization, but only when the previous privilege is not 3; otherwise virtualization becomes 0. The previous privilege becomes 0. The interrupt enable takes the saved enable, the saved enable becomes 1, and the previous virtualization becomes 0. The modify-privilege flag clears when the target level is below 3 and is kept when the target is 3.
- R5: A supervisor return sets the nominal privilege to {0, supervisor previous privilege}. It then clears the supervisor previous privilege and clears the modify-privilege flag. Virtualization is unchanged.
- R6: A status write loads all six fields at once. The previous privilege field stores a written 2 as 0. The write is ignored entirely while the nominal privilege is below 3.
- R7: After any trap, a modify-privilege flag of 1 comes with a previous privilege of 3. While the nominal privilege is below 3, the modify-privilege flag is 0.
- R8: When several strobes arrive in one cycle, only one takes effect. The trap is taken first, then the machine return, then the supervisor return, and the status write last.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trap_i | input | 1 | Trap into machine level |
| mret_i | input | 1 | Machine return |
| sret_i | input | 1 | Supervisor return |
| wr_en_i | input | 1 | Status field write strobe |
| wr_mpp_i | input | 2 | Written previous privilege |
| wr_mpv_i | input | 1 | Written previous virtualization |
| wr_mprv_i | input | 1 | Written modify-privilege flag |
| wr_mie_i | input | 1 | Written interrupt enable |
| wr_mpie_i | input | 1 | Written saved enable |
| wr_spp_i | input | 1 | Written supervisor previous privilege |
| nom_priv_o | output | 2 | Nominal privilege for fetch and implicit accesses |
| nom_virt_o | output | 1 | Nominal virtualization flag |
| eff_priv_o | output | 2 | Effective privilege for explicit loads and stores |
| eff_virt_o | output | 1 | Effective virtualization for explicit loads and stores |
| mpp_o | output | 2 | Previous privilege field |
| mpv_o | output | 1 | Previous virtualization field |
| mprv_o | output | 1 | Modify-privilege flag |
| mie_o | output | 1 | Interrupt enable |
| mpie_o | output | 1 | Saved interrupt enable |
| spp_o | output | 1 | Supervisor previous privilege |

## Verification
Two functions can land in the same cycle. In the first case, a trap and a status write that would clear the modify-privilege flag and change the previous privilege arrive together. The result is judged correct only if the fields show the trap's save pattern and the flag keeps its earlier value. In the second case, a machine return and a supervisor return arrive together while the previous privilege is 3 and the supervisor previous privilege is 0. The two returns would leave distinct privilege and flag values, so the result shows which one won. The invariant that a handler never sees the flag set with a lower saved level is checked after every trap.

// File: rtl/priv_state_unit.sv
module priv_state_unit (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       trap_i,
  input  logic       mret_i,
  input  logic       sret_i,
  input  logic       wr_en_i,
  input  logic [1:0] wr_mpp_i,
  input  logic       wr_mpv_i,
  input  logic       wr_mprv_i,
  input  logic       wr_mie_i,
  input  logic       wr_mpie_i,
  input  logic       wr_spp_i,
  output logic [1:0] nom_priv_o,
  output logic       nom_virt_o,
  output logic [1:0] eff_priv_o,
  output logic       eff_virt_o,
  output logic [1:0] mpp_o,
  output logic       mpv_o,
  output logic       mprv_o,
  output logic       mie_o,
  output logic       mpie_o,
  output logic       spp_o
);
  localparam logic [1:0] LVL_U = 2'd0;
  localparam logic [1:0] LVL_M = 2'd3;

  logic [1:0] priv_q, mpp_q;
  logic virt_q, mpv_q, mprv_q, mie_q, mpie_q, spp_q;

  logic in_m, do_mret, do_sret, do_wr, mret_low;
  assign in_m     = (priv_q == LVL_M);
  assign do_mret  = mret_i && !trap_i;
  assign do_sret  = sret_i && !trap_i && !mret_i;
  assign do_wr    = wr_en_i && in_m && !trap_i && !mret_i && !sret_i;
  assign mret_low = (mpp_q != LVL_M);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      priv_q <= LVL_M;
      virt_q <= 1'b0;
      mpp_q  <= LVL_U;
      mpv_q  <= 1'b0;
      mprv_q <= 1'b0;
      mie_q  <= 1'b0;
      mpie_q <= 1'b0;
      spp_q  <= 1'b0;
    end else if (trap_i) begin
      mpp_q  <= priv_q;
      mpv_q  <= virt_q;
      mpie_q <= mie_q;
      mie_q  <= 1'b0;
      priv_q <= LVL_M;
      virt_q <= 1'b0;
    end else if (do_mret) begin
      priv_q <= mpp_q;
      virt_q <= mret_low && mpv_q;
      mpp_q  <= LVL_U;
      mie_q  <= mpie_q;
      mpie_q <= 1'b1;
      mpv_q  <= 1'b0;
      if (mret_low) mprv_q <= 1'b0;
    end else if (do_sret) begin
      priv_q <= {1'b0, spp_q};
      spp_q  <= 1'b0;
      mprv_q <= 1'b0;
    end else if (do_wr) begin
      mpp_q  <= (wr_mpp_i == 2'd2) ? LVL_U : wr_mpp_i;
      mpv_q  <= wr_mpv_i;
      mprv_q <= wr_mprv_i;
      mie_q  <= wr_mie_i;
      mpie_q <= wr_mpie_i;
      spp_q  <= wr_spp_i;
    end
  end

  assign nom_priv_o = priv_q;
  assign nom_virt_o = virt_q;
  assign eff_priv_o = mprv_q ? mpp_q : priv_q;
  assign eff_virt_o = mprv_q ? mpv_q : virt_q;
  assign mpp_o  = mpp_q;
  assign mpv_o  = mpv_q;
  assign mprv_o = mprv_q;
  assign mie_o  = mie_q;
  assign mpie_o = mpie_q;
  assign spp_o  = spp_q;

  a_r2_trap_enters_m: assert property (@(posedge clk) disable iff (!rst_n)
    trap_i |=> (nom_priv_o == 2'd3) && !nom_virt_o);
  a_r2_trap_saves_level: assert property (@(posedge clk) disable iff (!rst_n)
    trap_i |=> (mpp_o == $past(nom_priv_o)) && (mpv_o == $past(nom_virt_o)));
  a_r7_handler_mprv: assert property (@(posedge clk) disable iff (!rst_n)
    trap_i |=> (!mprv_o || mpp_o == 2'd3));
  a_r7_low_no_mprv: assert property (@(posedge clk) disable iff (!rst_n)
    (nom_priv_o != 2'd3) |-> !mprv_o);
  a_r4_mret_low_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (mret_i && !trap_i && mpp_o != 2'd3) |=> !mprv_o && (nom_priv_o != 2'd3));
  a_r6_low_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && nom_priv_o != 2'd3 && !trap_i && !mret_i && !sret_i)
      |=> $stable(mpp_o) && $stable(mie_o) && $stable(mprv_o));
  a_r6_no_reserved_mpp: assert property (@(posedge clk) disable iff (!rst_n)
    mpp_o != 2'd2);
endmodule

// File: tb/sim_priv_state_unit.sv
`timescale 1ns/1ps
module sim_priv_state_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic trap_i = 0, mret_i = 0, sret_i = 0, wr_en_i = 0;
  logic [1:0] wr_mpp_i = 0;
  logic wr_mpv_i = 0, wr_mprv_i = 0, wr_mie_i = 0, wr_mpie_i = 0, wr_spp_i = 0;
  logic [1:0] nom_priv_o, eff_priv_o, mpp_o;
  logic nom_virt_o, eff_virt_o, mpv_o, mprv_o, mie_o, mpie_o, spp_o;

  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;

  priv_state_unit u0 (
    .clk(clk), .rst_n(rst_n), .trap_i(trap_i), .mret_i(mret_i), .sret_i(sret_i),
    .wr_en_i(wr_en_i), .wr_mpp_i(wr_mpp_i), .wr_mpv_i(wr_mpv_i), .wr_mprv_i(wr_mprv_i),
    .wr_mie_i(wr_mie_i), .wr_mpie_i(wr_mpie_i), .wr_spp_i(wr_spp_i),
    .nom_priv_o(nom_priv_o), .nom_virt_o(nom_virt_o), .eff_priv_o(eff_priv_o),
    .eff_virt_o(eff_virt_o), .mpp_o(mpp_o), .mpv_o(mpv_o), .mprv_o(mprv_o),
    .mie_o(mie_o), .mpie_o(mpie_o), .spp_o(spp_o));

  // op: 1 trap, 2 mret, 3 sret, 4 write; wd {mpp,mpv,mprv,mie,mpie,spp}
  // exp {priv,virt,mprv,mpp,mpv,mie,mpie,spp}
  localparam logic [19:0] VEC [12] = '{
    {3'd4, 7'b01_1_0_1_1_1, 10'b11_0_0_01_1_1_1_1},
    {3'd2, 7'b00_0_0_0_0_0, 10'b01_1_0_00_0_1_1_1},
    {3'd1, 7'b00_0_0_0_0_0, 10'b11_0_0_01_1_0_1_1},
    {3'd4, 7'b10_0_1_0_0_0, 10'b11_0_1_00_0_0_0_0},
    {3'd3, 7'b00_0_0_0_0_0, 10'b00_0_0_00_0_0_0_0},
    {3'd4, 7'b11_1_1_1_1_1, 10'b00_0_0_00_0_0_0_0},
    {3'd1, 7'b00_0_0_0_0_0, 10'b11_0_0_00_0_0_0_0},
    {3'd4, 7'b11_0_1_1_0_1, 10'b11_0_1_11_0_1_0_1},
    {3'd2, 7'b00_0_0_0_0_0, 10'b11_0_1_00_0_0_1_1},
    {3'd1, 7'b00_0_0_0_0_0, 10'b11_0_1_11_0_0_0_1},
    {3'd3, 7'b00_0_0_0_0_0, 10'b01_0_0_11_0_0_0_0},
    {3'd2, 7'b00_0_0_0_0_0, 10'b11_0_0_00_0_0_1_0}
  };

  function automatic logic [9:0] state_now();
    return {nom_priv_o, nom_virt_o, mprv_o, mpp_o, mpv_o, mie_o, mpie_o, spp_o};
  endfunction

  task automatic check(input string req, input logic [9:0] act, input logic [9:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic drive(input logic t, input logic m, input logic s, input logic w,
                       input logic [6:0] wd);
    @(negedge clk);
    trap_i = t; mret_i = m; sret_i = s; wr_en_i = w;
    {wr_mpp_i, wr_mpv_i, wr_mprv_i, wr_mie_i, wr_mpie_i, wr_spp_i} = wd;
    @(negedge clk);
    trap_i = 0; mret_i = 0; sret_i = 0; wr_en_i = 0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    @(negedge clk); @(negedge clk); rst_n = 1;
  endtask

  initial begin
    #100000;
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    do_reset();
    check("R1 reset state", state_now(), 10'b11_0_0_00_0_0_0_0);

    for (int i = 0; i < 12; i++) begin
      logic [2:0] op;
      logic [6:0] wd;
      string tag;
      op = VEC[i][19:17];
      wd = VEC[i][16:10];
      case (op)
        3'd1: tag = "R2 R7 trap";
        3'd2: tag = "R4 mret";
        3'd3: tag = "R5 sret";
        default: tag = "R6 write";
      endcase
      drive(op == 3'd1, op == 3'd2, op == 3'd3, op == 3'd4, wd);
      check($sformatf("%s vector %0d", tag, i), state_now(), VEC[i][9:0]);
    end

    do_reset();
    check("R1 reset after run", state_now(), 10'b11_0_0_00_0_0_0_0);

    // modify-privilege on: data view moves, nominal view stays
    drive(0, 0, 0, 1, 7'b01_1_1_0_0_0);
    check("R3 effective view", {4'b0, eff_priv_o, eff_virt_o, nom_priv_o, nom_virt_o},
          {4'b0, 2'd1, 1'b1, 2'd3, 1'b0});

    // trap with a write in the same cycle: trap wins
    drive(1, 0, 0, 1, 7'b00_0_0_1_1_1);
    check("R8 trap over write", state_now(), 10'b11_0_1_11_0_0_0_0);
    check("R7 handler entry", {8'b0, mprv_o, (mpp_o == 2'd3)}, 10'b11);

    // both returns together: machine return wins (sret would give priv 0, flag 0)
    drive(0, 1, 1, 0, 7'b0);
    check("R8 mret over sret", state_now(), 10'b11_0_1_00_0_0_1_0);

    // flag still set: effective view uses previous level 0 with nominal 3
    check("R3 effective after return", {6'b0, eff_priv_o, nom_priv_o}, {6'b0, 2'd0, 2'd3});

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule